// File: doc/BRIEF.md
# SCSI Bus Controller Register Interface

This block is the host-facing register file of a parallel SCSI protocol controller. A CPU reaches it through a byte-wide port with a three-bit address and separate read and write strobes. Through it, software asserts the bus control lines and the data lines, picks the phase to present when acting as a target, and reads the live state of every bus line. On a read, several addresses return a different register from the one the same address writes.

The block sits beside the bus transceivers. Each control line and the data byte come in as an active-high sampled input, already resolved across all devices on the bus. Each line goes out as an active-high enable that tells the external driver to pull the line active. The block also watches the bus for three conditions and latches each into a single interrupt output: a selection aimed at an enabled ID, a parity error on a received byte, and an unexpected loss of BSY. Reading address 7 acknowledges all pending conditions.

Top module: `sbc_ctrl`

## Requirements
- R1: After reset, the initiator, mode, target and mask registers and the output data register are all zero, every output enable is low, and `irq` is low.
- R2: Address 1 reads back {assert-RST (bit 7), mode bit 0 (bit 6), 0 (bit 5), assert-ACK, assert-BSY, assert-SEL, assert-ATN, assert-data (bits 4..0)}. The bit 5 write value is ignored, and the bit 6 write value never reads back. Address 2 reads back the mode byte unchanged. Address 3 reads back target bits 3..0, with bits 7..4 read as zero.
- R3: Address 0 writes the output data byte and reads the live bus data. Address 4 reads {RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP} from bit 7 down to bit 0, taken from the live lines. The control vector layout is bit 8 RST, 7 BSY, 6 SEL, 5 ATN, 4 ACK, 3 REQ, 2 MSG, 1 C/D, 0 I/O.
- R4: The control enables are RST, BSY and SEL from initiator bits 7, 3 and 2. ATN and ACK come from initiator bits 1 and 4, but only while mode bit 6 (target mode) is clear. REQ, MSG, C/D and I/O come from target bits 3..0, but only while mode bit 6 is set. When initiator write bit 6 (tri-state) is set, every enable is held low.
- R5: The data enable is high when the drivers are not tri-stated and either mode bit 0 (arbitrate) is set, or initiator bit 0 is set while the phase matches. The data output is the output data byte, and the parity output is its odd parity bit.
- R6: Address 5 bit 3 (phase match) is 1 exactly when the live MSG, C/D and I/O lines equal target bits 2, 1 and 0.
- R7: When BSY is inactive, SEL is active, and a data line whose bit is set in the select mask (written at address 4) is active, a selection interrupt is latched at the next edge. It is not latched when only unmasked data lines are active.
- R8: A byte is sampled in the cycle in which the handshake line rises: REQ in initiator mode, ACK in target mode. With mode bit 5 set, a sample whose eight data bits plus DBP hold an even number of ones sets the parity flag at address 5 bit 5. It raises `irq` only if mode bit 4 is also set.
- R9: With mode bit 2 set, a high-to-low change of live BSY sets the busy-error flag at address 5 bit 2 and raises `irq`. With mode bit 2 clear, the flag stays clear.
- R10: A read strobe at address 7 clears the parity flag, the busy-error flag and all pending interrupts. A condition that arrives in the same cycle as the clear stays latched.
- R11: `irq` is the OR of the pending selection, parity-interrupt and busy-error conditions, and it is mirrored at address 5 bit 4. Address 5 bits 1 and 0 show live ATN and ACK, and bits 7 and 6 read zero.
- R12: Writes to addresses 5, 6 and 7 change no register. Addresses 6 and 7 read as zero. The select mask cannot be read, because address 4 reads bus status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe; only address 7 has a side effect |
| host_rdata | output | DATA_W | Read data for host_addr, combinational |
| irq | output | 1 | Interrupt request, level |
| bus_ctl_in | input | 9 | Live control lines, active high (layout in R3) |
| bus_data_in | input | DATA_W | Live data lines, active high |
| bus_dbp_in | input | 1 | Live data parity line |
| bus_ctl_oe | output | 9 | Control line enables, same layout |
| bus_data_out | output | DATA_W | Data byte to drive |
| bus_data_oe | output | 1 | Enable for data and parity lines |
| bus_dbp_out | output | 1 | Parity bit to drive |

## Verification
The assertions assume that the bus inputs are synchronous to `clk` and that they already include what this block drives, so the live lines are the OR of the block's own enables and the other devices. They also assume that a host strobe lasts one cycle and that write and read strobes never come together. The stimulus keeps to these assumptions. The bench derives every bus input from the design's enables ORed with a random pattern from other devices, changes that pattern only at the falling clock edge, and issues at most one strobe per cycle. The tri-state bit is written only now and then, so the drive paths are exercised most of the time.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   // control line positions in bus_ctl_in / bus_ctl_oe
   localparam int CTL_W  = 9;
   localparam int CL_IO  = 0;
   localparam int CL_CD  = 1;
   localparam int CL_MSG = 2;
   localparam int CL_REQ = 3;
   localparam int CL_ACK = 4;
   localparam int CL_ATN = 5;
   localparam int CL_SEL = 6;
   localparam int CL_BSY = 7;
   localparam int CL_RST = 8;

   // register addresses
   localparam int RA_DATA   = 0;
   localparam int RA_INIT   = 1;
   localparam int RA_MODE   = 2;
   localparam int RA_TGT    = 3;
   localparam int RA_STAT   = 4;
   localparam int RA_BUS    = 5;
   localparam int RA_INDATA = 6;
   localparam int RA_ACKIRQ = 7;

   // initiator register bits
   localparam int IB_DATA = 0;
   localparam int IB_ATN  = 1;
   localparam int IB_SEL  = 2;
   localparam int IB_BSY  = 3;
   localparam int IB_ACK  = 4;
   localparam int IB_TRI  = 6;
   localparam int IB_RST  = 7;

   // mode register bits
   localparam int MB_ARB    = 0;
   localparam int MB_MONBSY = 2;
   localparam int MB_PARINT = 4;
   localparam int MB_PARCHK = 5;
   localparam int MB_TGT    = 6;

   localparam int TGT_W = 4;
endpackage

// File: rtl/sbc_regs.sv
module sbc_regs import sbc_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] odr_q,
   output logic [DATA_W-1:0] icr_q,
   output logic [DATA_W-1:0] mode_q,
   output logic [TGT_W-1:0]  tgt_q,
   output logic [DATA_W-1:0] mask_q
);
   localparam logic [DATA_W-1:0] ICR_KEEP = ~(DATA_W'(1) << 5);

   logic wr_odr, wr_icr, wr_mode, wr_tgt, wr_mask;

   always_comb begin
      wr_odr  = wr && (addr == ADDR_W'(RA_DATA));
      wr_icr  = wr && (addr == ADDR_W'(RA_INIT));
      wr_mode = wr && (addr == ADDR_W'(RA_MODE));
      wr_tgt  = wr && (addr == ADDR_W'(RA_TGT));
      wr_mask = wr && (addr == ADDR_W'(RA_STAT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odr_q  <= '0;
         icr_q  <= '0;
         mode_q <= '0;
         tgt_q  <= '0;
         mask_q <= '0;
      end else begin
         if (wr_odr)  odr_q  <= wdata;
         if (wr_icr)  icr_q  <= wdata & ICR_KEEP;
         if (wr_mode) mode_q <= wdata;
         if (wr_tgt)  tgt_q  <= wdata[TGT_W-1:0];
         if (wr_mask) mask_q <= wdata;
      end
   end

   // the select mask moves only on a write to its own address
   p_mask_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr != ADDR_W'(RA_STAT)) |=> $stable(mask_q));
   // target register moves only on a write to address 3
   p_tgt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == ADDR_W'(RA_TGT)) |=> $stable(tgt_q));
endmodule

// File: rtl/sbc_busdrv.sv
module sbc_busdrv import sbc_pkg::*; #(
   parameter int DATA_W     = 8,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] icr,
   input  logic              tgt_mode,
   input  logic              arb,
   input  logic [TGT_W-1:0]  tgt,
   input  logic [DATA_W-1:0] odr,
   input  logic [CTL_W-1:0]  ctl_live,
   output logic [CTL_W-1:0]  ctl_oe,
   output logic              data_oe,
   output logic [DATA_W-1:0] data_out,
   output logic              dbp_out,
   output logic              phase_match
);
   logic             tri_st;
   logic [CTL_W-1:0] oe_raw;

   assign tri_st = icr[IB_TRI];

   always_comb begin
      oe_raw          = '0;
      oe_raw[CL_RST]  = icr[IB_RST];
      oe_raw[CL_BSY]  = icr[IB_BSY];
      oe_raw[CL_SEL]  = icr[IB_SEL];
      oe_raw[CL_ATN]  = icr[IB_ATN] & ~tgt_mode;
      oe_raw[CL_ACK]  = icr[IB_ACK] & ~tgt_mode;
      oe_raw[CL_REQ]  = tgt[3] & tgt_mode;
      oe_raw[CL_MSG]  = tgt[2] & tgt_mode;
      oe_raw[CL_CD]   = tgt[1] & tgt_mode;
      oe_raw[CL_IO]   = tgt[0] & tgt_mode;
   end

   assign phase_match = (ctl_live[CL_MSG] == tgt[2]) &&
                        (ctl_live[CL_CD]  == tgt[1]) &&
                        (ctl_live[CL_IO]  == tgt[0]);

   assign ctl_oe   = tri_st ? '0 : oe_raw;
   assign data_oe  = ~tri_st & (arb | (icr[IB_DATA] & phase_match));
   assign data_out = odr;

   generate
      if (PARITY_ODD) begin : g_par_odd
         assign dbp_out = ~(^odr);
      end else begin : g_par_even
         assign dbp_out = ^odr;
      end
   endgenerate

   // tri-state silences every driver
   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tri_st |-> (ctl_oe == '0 && !data_oe));
   // in target mode the initiator-only lines stay released
   p_tgt_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_mode |-> (!ctl_oe[CL_ACK] && !ctl_oe[CL_ATN]));
   // data drive needs arbitration or the assert-data request
   p_data_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (arb || icr[IB_DATA]));
endmodule

// File: rtl/sbc_events.sv
module sbc_events import sbc_pkg::*; #(
   parameter int DATA_W     = 8,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_live,
   input  logic [DATA_W-1:0] data_live,
   input  logic              dbp_live,
   input  logic [DATA_W-1:0] mask,
   input  logic              tgt_mode,
   input  logic              par_chk,
   input  logic              par_int,
   input  logic              mon_bsy,
   input  logic              clr,
   output logic              par_err,
   output logic              busy_err,
   output logic              irq
);
   logic hs_now, hs_q, bsy_q;
   logic hs_rise, par_bad, par_evt, bsy_fall, sel_evt;
   logic par_pend_q, sel_pend_q, par_err_q, busy_err_q;

   assign hs_now  = tgt_mode ? ctl_live[CL_ACK] : ctl_live[CL_REQ];
   assign hs_rise = hs_now & ~hs_q;

   generate
      if (PARITY_ODD) begin : g_chk_odd
         assign par_bad = ~(^{data_live, dbp_live});
      end else begin : g_chk_even
         assign par_bad = ^{data_live, dbp_live};
      end
   endgenerate

   assign par_evt  = hs_rise & par_chk & par_bad;
   assign bsy_fall = mon_bsy & bsy_q & ~ctl_live[CL_BSY];
   assign sel_evt  = ~ctl_live[CL_BSY] & ctl_live[CL_SEL] & (|(data_live & mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q       <= 1'b0;
         bsy_q      <= 1'b0;
         par_err_q  <= 1'b0;
         par_pend_q <= 1'b0;
         busy_err_q <= 1'b0;
         sel_pend_q <= 1'b0;
      end else begin
         hs_q       <= hs_now;
         bsy_q      <= ctl_live[CL_BSY];
         par_err_q  <= par_evt | (par_err_q & ~clr);
         par_pend_q <= (par_evt & par_int) | (par_pend_q & ~clr);
         busy_err_q <= bsy_fall | (busy_err_q & ~clr);
         sel_pend_q <= sel_evt | (sel_pend_q & ~clr);
      end
   end

   assign par_err  = par_err_q;
   assign busy_err = busy_err_q;
   assign irq      = par_pend_q | busy_err_q | sel_pend_q;

   // selection on an enabled ID raises the interrupt
   p_sel_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_evt |=> irq);
   // monitored BSY loss reports a busy error
   p_busy_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_bsy && bsy_q && !ctl_live[CL_BSY]) |=> busy_err);
   // clear with no new cause empties every flag
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !par_evt && !bsy_fall && !sel_evt) |=> (!irq && !par_err && !busy_err));
   // parity flag never rises while checking is off
   p_par_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_chk && !par_err) |=> !par_err);
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl import sbc_pkg::*; #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 3,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   input  logic [CTL_W-1:0]  bus_ctl_in,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic              bus_dbp_in,
   output logic [CTL_W-1:0]  bus_ctl_oe,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   output logic              bus_dbp_out
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("sbc_ctrl: DATA_W must be 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("sbc_ctrl: ADDR_W must be at least 3");
      end
   endgenerate

   logic [DATA_W-1:0] odr_q, icr_q, mode_q, mask_q;
   logic [TGT_W-1:0]  tgt_q;
   logic              phase_match, par_err, busy_err, clr;

   assign clr = host_rd && (host_addr == ADDR_W'(RA_ACKIRQ));

   sbc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
      .wdata(host_wdata), .odr_q(odr_q), .icr_q(icr_q),
      .mode_q(mode_q), .tgt_q(tgt_q), .mask_q(mask_q)
   );

   sbc_busdrv #(.DATA_W(DATA_W), .PARITY_ODD(PARITY_ODD)) u_drv (
      .clk(clk), .rst_n(rst_n), .icr(icr_q),
      .tgt_mode(mode_q[MB_TGT]), .arb(mode_q[MB_ARB]),
      .tgt(tgt_q), .odr(odr_q), .ctl_live(bus_ctl_in),
      .ctl_oe(bus_ctl_oe), .data_oe(bus_data_oe),
      .data_out(bus_data_out), .dbp_out(bus_dbp_out),
      .phase_match(phase_match)
   );

   sbc_events #(.DATA_W(DATA_W), .PARITY_ODD(PARITY_ODD)) u_evt (
      .clk(clk), .rst_n(rst_n), .ctl_live(bus_ctl_in),
      .data_live(bus_data_in), .dbp_live(bus_dbp_in), .mask(mask_q),
      .tgt_mode(mode_q[MB_TGT]), .par_chk(mode_q[MB_PARCHK]),
      .par_int(mode_q[MB_PARINT]), .mon_bsy(mode_q[MB_MONBSY]),
      .clr(clr), .par_err(par_err), .busy_err(busy_err), .irq(irq)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         ADDR_W'(RA_DATA): host_rdata = bus_data_in;
         ADDR_W'(RA_INIT): host_rdata = {icr_q[IB_RST], mode_q[MB_ARB], 1'b0,
                                         icr_q[IB_ACK], icr_q[IB_BSY], icr_q[IB_SEL],
                                         icr_q[IB_ATN], icr_q[IB_DATA]};
         ADDR_W'(RA_MODE): host_rdata = mode_q;
         ADDR_W'(RA_TGT):  host_rdata = {{(DATA_W-TGT_W){1'b0}}, tgt_q};
         ADDR_W'(RA_STAT): host_rdata = {bus_ctl_in[CL_RST], bus_ctl_in[CL_BSY],
                                         bus_ctl_in[CL_REQ], bus_ctl_in[CL_MSG],
                                         bus_ctl_in[CL_CD], bus_ctl_in[CL_IO],
                                         bus_ctl_in[CL_SEL], bus_dbp_in};
         ADDR_W'(RA_BUS):  host_rdata = {2'b00, par_err, irq, phase_match, busy_err,
                                         bus_ctl_in[CL_ATN], bus_ctl_in[CL_ACK]};
         default:          host_rdata = '0;
      endcase
   end

   // interrupt pin and its status mirror agree
   p_irq_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADDR_W'(RA_BUS)) |-> (host_rdata[4] == irq));
   // bus-status view follows the live BSY line
   p_stat_bsy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADDR_W'(RA_STAT)) |-> (host_rdata[6] == bus_ctl_in[CL_BSY]));
endmodule

// File: tb/sbc_ctrl_test.sv
module sbc_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic       irq;
   logic [8:0] oth_ctl = '0;
   logic [7:0] oth_data = '0;
   logic       oth_dbp = 1'b0;
   logic [8:0] bus_ctl_in, bus_ctl_oe;
   logic [7:0] bus_data_in, bus_data_out;
   logic       bus_dbp_in, bus_data_oe, bus_dbp_out;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign bus_ctl_in  = bus_ctl_oe | oth_ctl;
   assign bus_data_in = (bus_data_oe ? bus_data_out : 8'h00) | oth_data;
   assign bus_dbp_in  = (bus_data_oe & bus_dbp_out) | oth_dbp;

   sbc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .irq(irq),
      .bus_ctl_in(bus_ctl_in), .bus_data_in(bus_data_in), .bus_dbp_in(bus_dbp_in),
      .bus_ctl_oe(bus_ctl_oe), .bus_data_out(bus_data_out),
      .bus_data_oe(bus_data_oe), .bus_dbp_out(bus_dbp_out)
   );

   // reference state
   logic [7:0] m_odr, m_icr, m_mode, m_mask;
   logic [3:0] m_tgt;
   logic       m_par, m_parp, m_busy, m_selp, m_hsq, m_bsyq;
   // expected live values of the current cycle
   logic [8:0] e_oe, e_ctl;
   logic [7:0] e_data;
   logic       e_dbp, e_doe, e_phase;
   // sampled outputs of the last step
   logic [7:0] s_rdata;
   logic [8:0] s_oe;
   logic       s_irq, s_doe;

   function automatic logic odd_bit(input logic [7:0] v);
      return ~(^v);
   endfunction

   task automatic model_reset();
      m_odr = 0; m_icr = 0; m_mode = 0; m_mask = 0; m_tgt = 0;
      m_par = 0; m_parp = 0; m_busy = 0; m_selp = 0; m_hsq = 0; m_bsyq = 0;
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rdata(input logic [2:0] a);
      case (a)
         3'd0: return e_data;
         3'd1: return {m_icr[7], m_mode[0], 1'b0, m_icr[4:0]};
         3'd2: return m_mode;
         3'd3: return {4'h0, m_tgt};
         3'd4: return {e_ctl[8], e_ctl[7], e_ctl[3], e_ctl[2], e_ctl[1], e_ctl[0],
                       e_ctl[6], e_dbp};
         3'd5: return {2'b00, m_par, (m_parp | m_busy | m_selp), e_phase, m_busy,
                       e_ctl[5], e_ctl[4]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic compute_expected();
      logic tgtm;
      tgtm = m_mode[6];
      if (m_icr[6]) e_oe = '0;
      else e_oe = {m_icr[7], m_icr[3], m_icr[2], m_icr[1] & ~tgtm, m_icr[4] & ~tgtm,
                   tgtm ? m_tgt : 4'h0};
      e_ctl   = e_oe | oth_ctl;
      e_phase = (e_ctl[2:0] == m_tgt[2:0]);
      e_doe   = ~m_icr[6] & (m_mode[0] | (m_icr[0] & e_phase));
      e_data  = (e_doe ? m_odr : 8'h00) | oth_data;
      e_dbp   = (e_doe & odd_bit(m_odr)) | oth_dbp;
   endtask

   task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                       input logic [7:0] wd, input logic [8:0] oc,
                       input logic [7:0] od, input logic odp);
      logic [7:0] er;
      logic hs, clr, pev, bf, sev;
      @(negedge clk);
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
      oth_ctl = oc; oth_data = od; oth_dbp = odp;
      #5;
      compute_expected();
      s_rdata = host_rdata; s_oe = bus_ctl_oe; s_irq = irq; s_doe = bus_data_oe;
      er = exp_rdata(a);
      if (a == 3'd5) begin
         check(host_rdata[3] == er[3], "R6 phase match", host_rdata, er);
         check(host_rdata[5] == er[5], "R8 parity flag", host_rdata, er);
         check(host_rdata[2] == er[2], "R9 busy error", host_rdata, er);
         check({host_rdata[7:6], host_rdata[4], host_rdata[1:0]} ==
               {er[7:6], er[4], er[1:0]}, "R11 bus status", host_rdata, er);
      end else if (a == 3'd0 || a == 3'd4)
         check(host_rdata == er, "R3 live view", host_rdata, er);
      else if (a >= 3'd6)
         check(host_rdata == er, "R12 unused read", host_rdata, er);
      else
         check(host_rdata == er, "R2 readback", host_rdata, er);
      check(bus_ctl_oe == e_oe, "R4 control enables", bus_ctl_oe, e_oe);
      check(bus_data_oe == e_doe, "R5 data enable", bus_data_oe, e_doe);
      if (e_doe)
         check({bus_data_out, bus_dbp_out} == {m_odr, odd_bit(m_odr)},
               "R5 data and parity", {bus_data_out, bus_dbp_out}, {m_odr, odd_bit(m_odr)});
      check(irq == (m_parp | m_busy | m_selp), "R11 irq", irq, (m_parp | m_busy | m_selp));
      @(posedge clk);
      // reference update with values of this cycle
      hs  = m_mode[6] ? e_ctl[4] : e_ctl[3];
      clr = rd && a == 3'd7;
      pev = hs & ~m_hsq & m_mode[5] & ~(^{e_data, e_dbp});
      bf  = m_mode[2] & m_bsyq & ~e_ctl[7];
      sev = ~e_ctl[7] & e_ctl[6] & (|(e_data & m_mask));
      m_par  = pev | (m_par & ~clr);
      m_parp = (pev & m_mode[4]) | (m_parp & ~clr);
      m_busy = bf | (m_busy & ~clr);
      m_selp = sev | (m_selp & ~clr);
      m_hsq  = hs;
      m_bsyq = e_ctl[7];
      if (wr) case (a)
         3'd0: m_odr = wd;
         3'd1: m_icr = wd & 8'hDF;
         3'd2: m_mode = wd;
         3'd3: m_tgt = wd[3:0];
         3'd4: m_mask = wd;
         default: ;
      endcase
   endtask

   task automatic idle(input logic [8:0] oc, input logic [7:0] od, input logic odp);
      step(1'b0, 1'b0, 3'd0, 8'h00, oc, od, odp);
   endtask

   localparam logic [8:0] L_SEL = 9'h040, L_BSY = 9'h080, L_REQ = 9'h008;

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd5380));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      step(0, 1, 3'd1, 0, 0, 0, 0);
      check(s_rdata == 8'h00, "R1 initiator reg after reset", s_rdata, 0);
      check(s_oe == 9'h000 && !s_doe, "R1 enables after reset", s_oe, 0);
      check(s_irq == 1'b0, "R1 irq after reset", s_irq, 0);
      step(0, 1, 3'd2, 0, 0, 0, 0);
      check(s_rdata == 8'h00, "R1 mode after reset", s_rdata, 0);

      // R7 selection with mask
      step(1, 0, 3'd4, 8'h04, 0, 0, 0);
      idle(L_SEL, 8'h08, 0);
      idle(L_SEL, 8'h04, 0);
      check(s_irq == 1'b0, "R7 unmasked ID ignored", s_irq, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_irq == 1'b1 && s_rdata[4], "R7 selection irq", s_irq, 1);

      // R10 clear and set-wins
      step(0, 1, 3'd7, 0, 0, 0, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_irq == 1'b0, "R10 cleared", s_irq, 0);
      idle(L_SEL, 8'h04, 0);
      step(0, 1, 3'd7, 0, L_SEL, 8'h04, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_irq == 1'b1, "R10 new cause survives clear", s_irq, 1);
      step(0, 1, 3'd7, 0, 0, 0, 0);

      // R9 busy monitor
      step(1, 0, 3'd2, 8'h04, 0, 0, 0);
      idle(L_BSY, 0, 0);
      idle(0, 0, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_rdata[2] == 1'b1 && s_irq, "R9 BSY loss flagged", s_rdata, 8'h14);
      step(0, 1, 3'd7, 0, 0, 0, 0);
      step(1, 0, 3'd2, 8'h00, 0, 0, 0);
      idle(L_BSY, 0, 0);
      idle(0, 0, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_rdata[2] == 1'b0 && !s_irq, "R9 unmonitored drop", s_rdata, 0);

      // R8 parity on REQ rise (initiator mode)
      step(1, 0, 3'd2, 8'h30, 0, 0, 0);
      idle(0, 8'h01, 1);
      idle(L_REQ, 8'h01, 1);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_rdata[5] == 1'b1 && s_irq, "R8 bad parity with irq", s_rdata, 8'h30);
      step(0, 1, 3'd7, 0, 0, 0, 0);
      idle(L_REQ, 8'h01, 0);
      idle(0, 8'h01, 0);
      idle(L_REQ, 8'h01, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_rdata[5] == 1'b0, "R8 good parity", s_rdata, 0);
      step(1, 0, 3'd2, 8'h20, 0, 0, 0);
      idle(0, 8'h03, 0);
      idle(L_REQ, 8'h03, 0);
      step(0, 1, 3'd5, 0, 0, 0, 0);
      check(s_rdata[5] == 1'b1 && !s_irq, "R8 flag without irq", s_rdata, 8'h20);
      step(0, 1, 3'd7, 0, 0, 0, 0);

      // R4 / R2 tri-state, R5 data drive
      step(1, 0, 3'd1, 8'hDF, 0, 0, 0);
      step(0, 1, 3'd1, 0, 0, 0, 0);
      check(s_oe == 9'h000 && !s_doe, "R4 tri-state", s_oe, 0);
      check(s_rdata == 8'h9F, "R2 icr readback", s_rdata, 8'h9F);
      step(1, 0, 3'd1, 8'h9F, 0, 0, 0);
      step(0, 1, 3'd1, 0, 0, 0, 0);
      check(s_oe == 9'h1F0, "R4 initiator drives", s_oe, 9'h1F0);
      check(s_doe == 1'b1, "R5 assert-data with phase match", s_doe, 1);

      // R12 ignored writes
      step(1, 0, 3'd5, 8'hFF, 0, 0, 0);
      step(1, 0, 3'd6, 8'hFF, 0, 0, 0);
      step(1, 0, 3'd7, 8'hFF, 0, 0, 0);
      step(0, 1, 3'd2, 0, 0, 0, 0);
      check(s_rdata == 8'h20, "R12 mode untouched", s_rdata, 8'h20);
      step(1, 0, 3'd1, 8'h00, 0, 0, 0);
      step(0, 1, 3'd7, 0, 0, 0, 0);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int unsigned op;
         logic [2:0] a;
         logic [7:0] d;
         op = $urandom % 8;
         a  = 3'($urandom);
         d  = 8'($urandom);
         if (a == 3'd1 && ($urandom % 4) != 0) d[6] = 1'b0;
         if (op < 3)
            step(1, 0, a, d, 9'($urandom & $urandom), 8'($urandom), 1'($urandom));
         else if (op < 6)
            step(0, 1, a, 0, 9'($urandom & $urandom), 8'($urandom), 1'($urandom));
         else
            idle(9'($urandom & $urandom), 8'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule